// File: doc/BRIEF.md
# Dithered Quadrature Oscillator

This block is the local oscillator of a digital downconverter. A 32-bit phase accumulator advances by a programmable tuning word on every input-sample strobe. A programmable phase offset is added to the accumulator's output phase, and the top bits of the resulting phase address a quarter-wave sine table. The table is folded by quadrant to give signed sine and cosine samples that a mixer downstream can use.

Two independent dither options come from one internal 32-bit shift-register noise source. Phase dither adds noise below the table's address bits before truncation, which spreads truncation spurs. Amplitude dither adds ±1 LSB to both outputs, with saturation at full scale. A sync input can return the accumulator to zero. Software first writes a mask that limits the strobe counts at which a sync pulse is honoured, which sets how often the phase can be realigned.

Top module: `nco_dither`

## Requirements
- R1: While reset is asserted, all configuration words are zero, the accumulator is zero, the noise register holds 32'h0000_0001, the sample counter is zero, no sync is pending, and sin_out, cos_out and out_valid are 0.
- R2: On each cycle with samp_en high, the accumulator gains the tuning word modulo 2^32. out_valid is high exactly in the cycle after a samp_en cycle. sin_out and cos_out change only in the cycle after a samp_en cycle and otherwise hold.
- R3: The 16-bit offset word is added to accumulator bits 31..16 to form the output phase. The accumulator itself is not affected by the offset.
- R4: Outputs are registered from the accumulator value before that strobe's update. With p the top 12 bits of the output phase, sin_out = round(32767·sin(2π(p+0.5)/4096)) and cos_out = round(32767·cos(2π(p+0.5)/4096)), rounded half away from zero. They are built from a quarter-wave table indexed by p[9:0] and folded by p[11:10].
- R5: When control bit 1 is set, the low 18 bits of the noise register are added to the output phase before the top 12 bits are taken.
- R6: When control bit 2 is set, noise bit 31 adds +1 (if 1) or −1 (if 0) to the sine value, and noise bit 30 does the same for the cosine value. The two dither enables work independently.
- R7: After amplitude dither, each output is clamped to the range −32768..32767.
- R8: The noise register advances once per samp_en. The next state is (s >> 1) XOR (s[0] ? 32'h8020_0003 : 0).
- R9: An 8-bit sample counter increments on every samp_en. A sync_in pulse is accepted only if (counter AND mask) equals zero in that cycle. Rejected pulses have no effect on the phase.
- R10: After an accepted sync, the next samp_en loads zero into the accumulator instead of adding the tuning word. A strobe in the same cycle as the pulse does not consume it.
- R11: A write (wr_en high) stores wr_data in one register, selected by wr_addr: 0 = control (bits 1 and 2), 1 = sync mask (bits 7..0), 2 = tuning word (bits 31..0), 3 = phase offset (bits 15..0). Addresses 4 to 7 change nothing. Each write takes effect from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | 32 | Register write value |
| samp_en | input | 1 | Input-sample strobe; advances the oscillator |
| sync_in | input | 1 | Phase resynchronisation request |
| sin_out | output | 16 | Signed sine sample |
| cos_out | output | 16 | Signed cosine sample |
| out_valid | output | 1 | High in the cycle after a strobe |

## Verification
Every cycle, the assertions check the strobe-to-valid timing and that outputs hold between strobes. They also check that the accumulator adds the tuning word or clears when a sync is pending, that a pulse rejected by the mask leaves nothing pending, that the noise register never reaches zero, and that writes to unused addresses leave the configuration untouched. The exact table values under quadrant folding, the effect of both dither paths, saturation at the positive peak, and the way sync acceptance depends on the mask and the sample count can only be shown by the bench's reference model. That model is driven through full sweeps of the table, random strobe gaps and random sync patterns.

// File: rtl/nco_dither_pkg.sv
package nco_dither_pkg;

   localparam int          LFSR_W    = 32;
   localparam logic [31:0] LFSR_TAPS = 32'h8020_0003;
   localparam logic [31:0] LFSR_SEED = 32'h0000_0001;

   localparam int CTRL_PDITH_BIT = 1;
   localparam int CTRL_ADITH_BIT = 2;

   typedef enum logic [2:0] {
      ADDR_CTRL = 3'd0,
      ADDR_MASK = 3'd1,
      ADDR_FREQ = 3'd2,
      ADDR_OFFS = 3'd3
   } reg_addr_e;

   typedef struct packed {
      logic ph_dith;
      logic amp_dith;
   } dith_cfg_t;

   function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
      return (s >> 1) ^ (s[0] ? LFSR_TAPS : '0);
   endfunction

endpackage

// File: rtl/nco_dither_regs.sv
module nco_dither_regs
   import nco_dither_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int OFF_W  = 16,
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        wr_addr,
   input  logic [ACC_W-1:0]  wr_data,
   output dith_cfg_t         cfg,
   output logic [MASK_W-1:0] mask,
   output logic [ACC_W-1:0]  fw,
   output logic [OFF_W-1:0]  off
);

   if (OFF_W > ACC_W || MASK_W > ACC_W) begin : g_bad_width
      $error("register fields wider than write port");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg  <= '0;
         mask <= '0;
         fw   <= '0;
         off  <= '0;
      end else if (wr_en) begin
         case (reg_addr_e'(wr_addr))
            ADDR_CTRL: begin
               cfg.ph_dith  <= wr_data[CTRL_PDITH_BIT];
               cfg.amp_dith <= wr_data[CTRL_ADITH_BIT];
            end
            ADDR_MASK: mask <= wr_data[MASK_W-1:0];
            ADDR_FREQ: fw   <= wr_data;
            ADDR_OFFS: off  <= wr_data[OFF_W-1:0];
            default: ;
         endcase
      end
   end

   // R11: unused addresses leave every field unchanged
   a_r11_unused_addr: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr[2]) |=> ($stable(cfg) && $stable(mask) && $stable(fw) && $stable(off)));

endmodule

// File: rtl/nco_dither_phase.sv
module nco_dither_phase
   import nco_dither_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int OFF_W  = 16,
   parameter int LUT_W  = 12,
   parameter int DITH_W = 18,
   parameter int MASK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              samp_en,
   input  logic              sync_in,
   input  logic              ph_dith,
   input  logic [ACC_W-1:0]  fw,
   input  logic [OFF_W-1:0]  off,
   input  logic [MASK_W-1:0] mask,
   output logic [LUT_W-1:0]  phase_top,
   output logic [1:0]        amp_bits
);

   localparam int LOW_W = ACC_W - LUT_W;
   localparam int SH    = ACC_W - OFF_W;

   if (LUT_W >= ACC_W || DITH_W > LOW_W || DITH_W > LFSR_W || DITH_W < 1) begin : g_bad_dith
      $error("dither must fit below the table address bits");
   end

   logic [ACC_W-1:0]  acc;
   logic [ACC_W-1:0]  off_full;
   logic              pend;
   logic [MASK_W-1:0] sctr;
   logic [LFSR_W-1:0] lfsr;
   logic [LOW_W-1:0]  dith;
   logic [LOW_W-1:0]  lo_sum;
   logic              c_off;
   logic              c_dith;
   logic              accept;

   assign off_full = ACC_W'(off) << SH;
   assign dith     = ph_dith ? LOW_W'(lfsr[DITH_W-1:0]) : '0;

   // carries out of the discarded low field, computed by compare
   assign c_off     = acc[LOW_W-1:0] > ~off_full[LOW_W-1:0];
   assign lo_sum    = acc[LOW_W-1:0] + off_full[LOW_W-1:0];
   assign c_dith    = lo_sum > ~dith;
   assign phase_top = acc[ACC_W-1 -: LUT_W] + off_full[ACC_W-1 -: LUT_W]
                    + LUT_W'(c_off) + LUT_W'(c_dith);
   assign amp_bits  = lfsr[LFSR_W-1 -: 2];

   assign accept = sync_in && ((sctr & mask) == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc  <= '0;
         pend <= 1'b0;
         sctr <= '0;
         lfsr <= LFSR_SEED;
      end else begin
         if (samp_en) begin
            acc  <= pend ? '0 : acc + fw;
            lfsr <= lfsr_step(lfsr);
            sctr <= sctr + MASK_W'(1);
         end
         if (accept)       pend <= 1'b1;
         else if (samp_en) pend <= 1'b0;
      end
   end

   // R2: accumulate by the tuning word when no sync is pending
   a_r2_acc_add: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && !pend) |=> (acc == $past(acc) + $past(fw)));

   // R2: accumulator frozen between strobes
   a_r2_acc_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> $stable(acc));

   // R10: pending sync clears the accumulator on the strobe
   a_r10_sync_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && pend) |=> (acc == '0));

   // R9: a masked-out pulse leaves nothing pending
   a_r9_masked_reject: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_in && ((sctr & mask) != '0) && !pend && !samp_en) |=> !pend);

   // R8: noise register never locks at zero
   a_r8_lfsr_live: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr != '0);

endmodule

// File: rtl/nco_dither_sincos.sv
module nco_dither_sincos #(
   parameter int LUT_W = 12,
   parameter int OUT_W = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    samp_en,
   input  logic [LUT_W-1:0]        phase_top,
   input  logic                    amp_dith,
   input  logic [1:0]              amp_bits,
   output logic signed [OUT_W-1:0] sin_o,
   output logic signed [OUT_W-1:0] cos_o,
   output logic                    valid_o
);

   localparam int QBITS = LUT_W - 2;
   localparam int QN    = 1 << QBITS;
   localparam int AMP   = (1 << (OUT_W - 1)) - 1;
   localparam logic signed [OUT_W:0] MAXV = (OUT_W+1)'(AMP);
   localparam logic signed [OUT_W:0] MINV = -MAXV - (OUT_W+1)'(1);

   if (LUT_W < 3 || LUT_W > 14 || OUT_W < 4 || OUT_W > 30) begin : g_bad_lut
      $error("table or output width out of supported range");
   end

   function automatic int quarter_val(input int i);
      real a;
      a = 1.5707963267948966 * (real'(i) + 0.5) / real'(QN);
      return $rtoi(real'(AMP) * $sin(a) + 0.5);
   endfunction

   function automatic logic signed [OUT_W-1:0] clamp(input logic signed [OUT_W:0] v);
      if (v > MAXV)      return MAXV[OUT_W-1:0];
      else if (v < MINV) return MINV[OUT_W-1:0];
      else               return v[OUT_W-1:0];
   endfunction

   logic signed [OUT_W-1:0] qrom [QN];

   for (genvar gi = 0; gi < QN; gi++) begin : g_rom
      localparam int V = quarter_val(gi);
      assign qrom[gi] = OUT_W'(V);
   end

   logic [QBITS-1:0]        idx;
   logic [1:0]              quad;
   logic signed [OUT_W-1:0] qa, qb, s_base, c_base;
   logic signed [OUT_W:0]   s_del, c_del, s_sum, c_sum;

   assign idx  = phase_top[QBITS-1:0];
   assign quad = phase_top[LUT_W-1 -: 2];
   assign qa   = qrom[idx];
   assign qb   = qrom[~idx];

   always_comb begin
      case (quad)
         2'd0:    begin s_base =  qa; c_base =  qb; end
         2'd1:    begin s_base =  qb; c_base = -qa; end
         2'd2:    begin s_base = -qa; c_base = -qb; end
         default: begin s_base = -qb; c_base =  qa; end
      endcase
   end

   assign s_del = !amp_dith ? '0 : (amp_bits[1] ? (OUT_W+1)'(1) : '1);
   assign c_del = !amp_dith ? '0 : (amp_bits[0] ? (OUT_W+1)'(1) : '1);
   assign s_sum = {s_base[OUT_W-1], s_base} + s_del;
   assign c_sum = {c_base[OUT_W-1], c_base} + c_del;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sin_o   <= '0;
         cos_o   <= '0;
         valid_o <= 1'b0;
      end else begin
         valid_o <= samp_en;
         if (samp_en) begin
            sin_o <= clamp(s_sum);
            cos_o <= clamp(c_sum);
         end
      end
   end

   // R2: valid follows the strobe by one cycle
   a_r2_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      samp_en |=> valid_o);
   a_r2_no_valid_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> !valid_o);

   // R2: samples hold between strobes
   a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !samp_en |=> ($stable(sin_o) && $stable(cos_o)));

   // R4: undithered table output never reaches negative full scale
   a_r4_symmetric_range: assert property (@(posedge clk) disable iff (!rst_n)
      (samp_en && !amp_dith) |=> (sin_o != MINV[OUT_W-1:0] && cos_o != MINV[OUT_W-1:0]));

endmodule

// File: rtl/nco_dither.sv
module nco_dither
   import nco_dither_pkg::*;
#(
   parameter int ACC_W  = 32,
   parameter int OFF_W  = 16,
   parameter int LUT_W  = 12,
   parameter int DITH_W = 18,
   parameter int MASK_W = 8,
   parameter int OUT_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [2:0]       wr_addr,
   input  logic [ACC_W-1:0] wr_data,
   input  logic             samp_en,
   input  logic             sync_in,
   output logic [OUT_W-1:0] sin_out,
   output logic [OUT_W-1:0] cos_out,
   output logic             out_valid
);

   dith_cfg_t         cfg;
   logic [MASK_W-1:0] mask;
   logic [ACC_W-1:0]  fw;
   logic [OFF_W-1:0]  off;
   logic [LUT_W-1:0]  phase_top;
   logic [1:0]        amp_bits;
   logic signed [OUT_W-1:0] sin_s, cos_s;

   nco_dither_regs #(
      .ACC_W (ACC_W),
      .OFF_W (OFF_W),
      .MASK_W(MASK_W)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_addr(wr_addr),
      .wr_data(wr_data),
      .cfg    (cfg),
      .mask   (mask),
      .fw     (fw),
      .off    (off)
   );

   nco_dither_phase #(
      .ACC_W (ACC_W),
      .OFF_W (OFF_W),
      .LUT_W (LUT_W),
      .DITH_W(DITH_W),
      .MASK_W(MASK_W)
   ) u_phase (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_en  (samp_en),
      .sync_in  (sync_in),
      .ph_dith  (cfg.ph_dith),
      .fw       (fw),
      .off      (off),
      .mask     (mask),
      .phase_top(phase_top),
      .amp_bits (amp_bits)
   );

   nco_dither_sincos #(
      .LUT_W(LUT_W),
      .OUT_W(OUT_W)
   ) u_sincos (
      .clk      (clk),
      .rst_n    (rst_n),
      .samp_en  (samp_en),
      .phase_top(phase_top),
      .amp_dith (cfg.amp_dith),
      .amp_bits (amp_bits),
      .sin_o    (sin_s),
      .cos_o    (cos_s),
      .valid_o  (out_valid)
   );

   assign sin_out = sin_s;
   assign cos_out = cos_s;

endmodule

// File: tb/nco_dither_bench.sv
`timescale 1ns/1ps
module nco_dither_bench;

   localparam real PI = 3.14159265358979323846;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        samp_en = 1'b0;
   logic        sync_in = 1'b0;
   logic [15:0] sin_out, cos_out;
   logic        out_valid;

   int checks = 0;
   int errors = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   nco_dither u_nco_dither (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .samp_en(samp_en), .sync_in(sync_in),
      .sin_out(sin_out), .cos_out(cos_out), .out_valid(out_valid)
   );

   // ---------------- behavioural reference ----------------
   bit [31:0] m_acc, m_fw, m_lfsr, m_p;
   bit [15:0] m_off;
   bit [7:0]  m_mask, m_sctr;
   bit        m_pd, m_ad, m_pend, m_valid, m_live, m_ok;
   int        m_sin, m_cos, m_s, m_c, m_p12;
   int        sat_hits = 0, n_acc = 0, n_rej = 0, n_clr = 0;
   real       m_ang;

   function automatic int rnd(input real v);
      if (v >= 0.0) return int'($floor(v + 0.5));
      else          return -int'($floor(-v + 0.5));
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = 0; m_fw = 0; m_off = 0; m_mask = 0; m_sctr = 0;
         m_lfsr = 32'h1; m_pd = 0; m_ad = 0; m_pend = 0;
         m_valid = 0; m_sin = 0; m_cos = 0; m_live = 1;
      end else begin
         if (samp_en) begin
            m_p = m_acc + {m_off, 16'h0000} + (m_pd ? (m_lfsr & 32'h0003_FFFF) : 32'h0);
            m_p12 = int'(m_p >> 20);
            m_ang = 2.0 * PI * (real'(m_p12) + 0.5) / 4096.0;
            m_s = rnd(32767.0 * $sin(m_ang));
            m_c = rnd(32767.0 * $cos(m_ang));
            if (m_ad) begin
               m_s = m_s + (m_lfsr[31] ? 1 : -1);
               m_c = m_c + (m_lfsr[30] ? 1 : -1);
            end
            if (m_s > 32767) begin m_s = 32767; sat_hits++; end
            if (m_c > 32767) begin m_c = 32767; sat_hits++; end
            if (m_s < -32768) m_s = -32768;
            if (m_c < -32768) m_c = -32768;
            m_sin = m_s; m_cos = m_c;
         end
         m_valid = samp_en;
         m_ok = sync_in && ((m_sctr & m_mask) == 8'h00);
         if (sync_in) begin
            if (m_ok) n_acc++;
            else      n_rej++;
         end
         if (samp_en) begin
            if (m_pend) begin m_acc = 0; n_clr++; end
            else m_acc = m_acc + m_fw;
            if (m_lfsr[0]) m_lfsr = (m_lfsr >> 1) ^ 32'h8020_0003;
            else           m_lfsr = m_lfsr >> 1;
            m_sctr = m_sctr + 8'd1;
         end
         if (m_ok) m_pend = 1;
         else if (samp_en) m_pend = 0;
         if (wr_en) begin
            case (wr_addr)
               3'd0: begin m_pd = wr_data[1]; m_ad = wr_data[2]; end
               3'd1: m_mask = wr_data[7:0];
               3'd2: m_fw = wr_data;
               3'd3: m_off = wr_data[15:0];
               default: ;
            endcase
         end
      end
   end

   // ---------------- per-cycle comparison ----------------
   always @(negedge clk) begin
      if (rst_n && m_live) begin
         checks++;
         if (out_valid !== m_valid || int'($signed(sin_out)) != m_sin ||
             int'($signed(cos_out)) != m_cos) begin
            errors++;
            $display("FAIL %s: valid=%0b sin=%0d cos=%0d expected valid=%0b sin=%0d cos=%0d",
                     cur_req, out_valid, $signed(sin_out), $signed(cos_out), m_valid, m_sin, m_cos);
         end
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d; samp_en = 1'b0; sync_in = 1'b0;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic run(input int n, input int strobe_pct, input int sync_pct, input int junk_pct);
      for (int i = 0; i < n; i++) begin
         samp_en = (($urandom % 100) < strobe_pct);
         sync_in = (($urandom % 100) < sync_pct);
         if (($urandom % 100) < junk_pct) begin
            wr_en = 1'b1; wr_addr = 3'(4 + ($urandom % 4)); wr_data = $urandom;
         end else begin
            wr_en = 1'b0;
         end
         @(negedge clk);
      end
      samp_en = 1'b0; sync_in = 1'b0; wr_en = 1'b0;
      @(negedge clk);
   endtask

   task automatic check_true(input bit c, input string req, input string what, input int act, input int exp);
      checks++;
      if (!c) begin
         errors++;
         $display("FAIL %s: %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   // ---------------- watchdog ----------------
   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog (all requirements): run did not finish, actual=1 expected=0");
      finish_run();
   end

   // ---------------- scenarios ----------------
   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state at the ports
      check_true(sin_out == 16'h0 && cos_out == 16'h0 && out_valid == 1'b0, "R1",
                 "reset outputs", int'(sin_out) + int'(cos_out) + int'(out_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: first strobe after reset reflects a zero accumulator
      cur_req = "R1";
      run(3, 100, 0, 0);

      cur_req = "R2";
      wr(3'd2, 32'h0123_4567);
      run(200, 100, 0, 0);
      run(150, 35, 0, 0);

      cur_req = "R3";
      wr(3'd3, 32'h0000_5A00);
      run(120, 80, 0, 0);

      cur_req = "R4";
      wr(3'd3, 32'h0);
      wr(3'd2, 32'h0010_0000);
      run(4200, 100, 0, 0);
      wr(3'd2, 32'h0100_0000);
      run(300, 70, 0, 0);

      cur_req = "R5 R8";
      wr(3'd0, 32'h0000_0002);
      wr(3'd2, 32'h0001_3579);
      run(400, 90, 0, 0);

      cur_req = "R6";
      wr(3'd0, 32'h0000_0004);
      wr(3'd2, 32'h0010_0000);
      run(4200, 100, 0, 0);
      wr(3'd0, 32'h0000_0006);
      run(500, 85, 0, 0);

      cur_req = "R7";
      wr(3'd0, 32'h0000_0004);
      wr(3'd2, 32'h0);
      wr(3'd3, 32'h0000_4000);
      run(200, 100, 0, 0);
      wr(3'd3, 32'h0000_C000);
      run(100, 100, 0, 0);
      wr(3'd3, 32'h0);
      check_true(sat_hits > 0, "R7", "saturation events", sat_hits, 1);

      cur_req = "R10";
      wr(3'd0, 32'h0);
      wr(3'd1, 32'h0);
      wr(3'd2, 32'h0123_4567);
      run(400, 60, 8, 0);
      check_true(n_clr > 0, "R10", "sync clears seen", n_clr, 1);

      cur_req = "R9";
      wr(3'd1, 32'h0000_0003);
      run(600, 70, 30, 0);
      wr(3'd1, 32'h0000_000F);
      run(600, 90, 50, 0);
      check_true(n_acc > 0 && n_rej > 0, "R9", "accepted and rejected syncs", n_rej, 1);

      cur_req = "R11";
      wr(3'd1, 32'h0);
      wr(3'd0, 32'h0000_0006);
      run(600, 70, 5, 60);

      finish_run();
   end

endmodule